// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block collects thirty-two internal interrupt request lines and one encoded external request level, and presents the CPU with a single registered request. The request carries a 4-bit level and a 12-bit event code. Each internal source takes its priority from a 4-bit field inside one of four 16-bit priority registers. Several related sources, such as the underflow and capture lines of one timer or the four lines of one serial port, share one field. One write therefore retunes the whole group.

Software programs the block through a small write-only port. A 32-bit mask can be modified only through two write-one strobes: one address sets mask bits and the other clears them, so no read-modify-write is needed. The external input carries a 4-bit encoded level that maps directly to an event code. The CPU supplies its current mask level. A request is raised only for a winner whose priority is above that level. The winner's code and level then stay frozen for as long as the request is held.

Top module: `grp_intc`

## Requirements
- R1: After reset `irq_req`, `irq_lvl` and `irq_code` are zero, all priority fields are zero and no mask bit is set.
- R2: Priority field f (0..15) is bits [4*(f%4)+3 : 4*(f%4)] of priority register f/4, written at `wr_addr` 0..3. Internal source i has event code 0x400 + 0x20*i. Its field is: source 0 field 0, 1 field 1, 2-3 field 2, 4-6 field 3, 7-10 field 6, 11 field 4, 12-13 field 5, 14 field 15, 15 field 12, 16-20 field 13, 21-24 field 14, 25 field 7, 26 field 8, 27 field 9, 28 field 10, 29-31 field 11.
- R3: All sources that map to one field take the same priority, so one field write changes every member of the group.
- R4: A source whose field holds 0 never produces a request.
- R5: Among the eligible requests, the higher priority wins. Between internal sources of equal priority, the lower index wins.
- R6: Writing to `wr_addr` 4 sets every mask bit whose data bit is 1 and leaves the others alone. Mask bit i blocks internal source i.
- R7: Writing to `wr_addr` 5 clears every mask bit whose data bit is 1 and leaves the others alone.
- R8: An external level n from 0 to 14 is a request with code 0x200 + 0x20*n and priority 15-n. Level 15 means no external request. The external request wins a tie against an internal source of equal priority.
- R9: `irq_req` is raised only when the winning priority is strictly greater than `cpu_lvl`. `irq_lvl` then shows the winning priority.
- R10: While `irq_req` stays high, `irq_code` and `irq_lvl` do not change. If the winner changes, or drops out of eligibility, `irq_req` goes low for at least one cycle. Outputs follow the arbitration result one clock after inputs change.
- R11: Writes to `wr_addr` 6 and 7 and data bits 31:16 of a priority register write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Internal request lines, level sensitive |
| ext_lvl | input | 4 | Encoded external level, 15 = idle |
| cpu_lvl | input | 4 | Current CPU mask level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0-3 priority registers, 4 mask set, 5 mask clear |
| wr_data | input | 32 | Write data |
| irq_req | output | 1 | Request to the CPU |
| irq_lvl | output | 4 | Priority of the held request |
| irq_code | output | 12 | Event code of the held request |

## Verification
Two functions can meet in one cycle: holding a granted request frozen, and re-arbitration when a stronger source or a higher CPU level arrives. The bench provokes this by raising a higher-priority line, or raising `cpu_lvl`, while a request is held. One clock later it expects the request low with the old code still on `irq_code`. One clock after that it expects the new winner. Sweeps over every source, priority and CPU level, over every source pair, and over every external level are judged against an arithmetic model built from the field table.

// File: rtl/grp_intc.sv
module grp_intc #(
  parameter int          NSRC      = 32,
  parameter int          NREG      = 4,
  parameter logic [11:0] SRC_BASE  = 12'h400,
  parameter logic [11:0] EXT_BASE  = 12'h200,
  parameter logic [11:0] CODE_STEP = 12'h020
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_req,
  input  logic [3:0]  ext_lvl,
  input  logic [3:0]  cpu_lvl,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        irq_req,
  output logic [3:0]  irq_lvl,
  output logic [11:0] irq_code
);
  localparam int NFLD = NREG * 4;

  function automatic int field_of(input int i);
    if (i == 0) return 0;
    else if (i == 1) return 1;
    else if (i <= 3) return 2;
    else if (i <= 6) return 3;
    else if (i <= 10) return 6;
    else if (i == 11) return 4;
    else if (i <= 13) return 5;
    else if (i == 14) return 15;
    else if (i == 15) return 12;
    else if (i <= 20) return 13;
    else if (i <= 24) return 14;
    else if (i == 25) return 7;
    else if (i == 26) return 8;
    else if (i == 27) return 9;
    else if (i == 28) return 10;
    else return 11;
  endfunction

  logic [15:0] prio_q [NREG];
  logic [31:0] mask_q;
  logic [3:0]  fld     [NFLD];
  logic [3:0]  src_pri [NSRC];
  logic [3:0]  best_pri;
  logic [11:0] best_code;
  logic        eligible;

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    assign fld[f] = prio_q[f / 4][4 * (f % 4) +: 4];
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_pri[s] = fld[field_of(s)];
  end

  always_comb begin
    best_pri  = (ext_lvl != 4'hF) ? 4'hF - ext_lvl : 4'h0;
    best_code = EXT_BASE + CODE_STEP * {8'd0, ext_lvl};
    for (int i = 0; i < NSRC; i++) begin
      if (src_req[i] && !mask_q[i] && src_pri[i] > best_pri) begin
        best_pri  = src_pri[i];
        best_code = SRC_BASE + CODE_STEP * 12'(i);
      end
    end
  end

  assign eligible = best_pri > cpu_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) prio_q[r] <= '0;
      mask_q   <= '0;
      irq_req  <= 1'b0;
      irq_lvl  <= '0;
      irq_code <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          3'd0, 3'd1, 3'd2, 3'd3: prio_q[wr_addr[1:0]] <= wr_data[15:0];
          3'd4: mask_q <= mask_q | wr_data;
          3'd5: mask_q <= mask_q & ~wr_data;
          default: ;
        endcase
      end
      if (!irq_req) begin
        if (eligible) begin
          irq_req  <= 1'b1;
          irq_lvl  <= best_pri;
          irq_code <= best_code;
        end
      end else if (!(eligible && best_code == irq_code && best_pri == irq_lvl)) begin
        irq_req <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && $past(irq_req)) |-> ($stable(irq_code) && $stable(irq_lvl))); // R10
  AST_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > $past(cpu_lvl))); // R9
  AST_NONZERO_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl != 4'h0)); // R4
  AST_CODE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_code[4:0] == 5'd0)); // R2
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4) |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R6
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd5) |=> ((mask_q & $past(wr_data)) == 32'd0)); // R7
endmodule

// File: tb/grp_intc_test.sv
module grp_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic [3:0]  ext_lvl = 4'hF;
  logic [3:0]  cpu_lvl = 4'h0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        irq_req;
  logic [3:0]  irq_lvl;
  logic [11:0] irq_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_prio [4];
  logic [31:0] m_mask;

  grp_intc uut (.clk, .rst_n, .src_req, .ext_lvl, .cpu_lvl, .wr_en, .wr_addr,
                .wr_data, .irq_req, .irq_lvl, .irq_code);

  always #5 clk = ~clk;

  function automatic int fmap(input int i);
    case (i)
      0: return 0;   1: return 1;   2, 3: return 2;   4, 5, 6: return 3;
      7, 8, 9, 10: return 6;   11: return 4;   12, 13: return 5;
      14: return 15;   15: return 12;   16, 17, 18, 19, 20: return 13;
      21, 22, 23, 24: return 14;   25: return 7;   26: return 8;
      27: return 9;   28: return 10;   default: return 11;
    endcase
  endfunction

  function automatic int pri_of(input int i);
    int f;
    f = fmap(i);
    return int'((m_prio[f / 4] >> (4 * (f % 4))) & 16'hF);
  endfunction

  task automatic expect_now(input string tag, output bit e_req, output int e_lvl, output int e_code);
    int bp, bc;
    bp = (ext_lvl != 4'hF) ? 15 - int'(ext_lvl) : 0;
    bc = 'h200 + 'h20 * int'(ext_lvl);
    for (int i = 0; i < 32; i++)
      if (src_req[i] && !m_mask[i] && pri_of(i) > bp) begin
        bp = pri_of(i);
        bc = 'h400 + 'h20 * i;
      end
    e_req = bp > int'(cpu_lvl);
    e_lvl = bp;
    e_code = bc;
    if (tag == "") ;
  endtask

  task automatic chk(input string tag, input bit e_req, input int e_lvl, input int e_code);
    n_chk++;
    if (irq_req !== e_req || (e_req && (int'(irq_lvl) != e_lvl || int'(irq_code) != e_code))) begin
      n_fail++;
      $display("FAIL %s: req=%0b lvl=%0d code=%h expected req=%0b lvl=%0d code=%h",
               tag, irq_req, irq_lvl, irq_code, e_req, e_lvl, e_code[11:0]);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 3'd4) m_prio[a[1:0]] = d[15:0];
    else if (a == 3'd4) m_mask = m_mask | d;
    else if (a == 3'd5) m_mask = m_mask & ~d;
  endtask

  task automatic settle_check(input string tag);
    bit er; int el, ec;
    repeat (3) @(negedge clk);
    expect_now(tag, er, el, ec);
    chk(tag, er, el, ec);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 4; r++) m_prio[r] = '0;
    m_mask = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 1'b0, 0, 0);
    rst_n = 1'b1;
    src_req = '1;
    settle_check("R1 fields zero after reset");
    src_req = '0;

    // R4 R9 sweep: one source, every priority, every cpu level
    for (int i = 0; i < 32; i++)
      for (int p = 0; p < 16; p++) begin
        for (int r = 0; r < 4; r++) wr(3'(r), {16'h0, {4{4'(p)}}});
        src_req = 32'd1 << i;
        for (int c = 0; c < 16; c++) begin
          cpu_lvl = 4'(c);
          settle_check("R4 R9 single source sweep");
        end
        cpu_lvl = 4'h0;
      end
    src_req = '0;

    // R2 R3 one field at a time, all sources raised
    for (int f = 0; f < 16; f++) begin
      for (int r = 0; r < 4; r++) wr(3'(r), 32'h0);
      wr(3'(f / 4), 32'(9) << (4 * (f % 4)));
      src_req = '1;
      settle_check("R2 R3 field to group mapping");
      for (int i = 0; i < 32; i++) if (fmap(i) == f) begin
        src_req = 32'd1 << i;
        settle_check("R3 each group member uses shared field");
      end
      src_req = '0;
    end

    // R5 pairwise arbitration, two priority patterns
    for (int k = 0; k < 2; k++) begin
      wr(3'd0, k ? 32'h3A5C : 32'h7777);
      wr(3'd1, k ? 32'h71E2 : 32'h7777);
      wr(3'd2, k ? 32'h9B48 : 32'h7777);
      wr(3'd3, k ? 32'hF06D : 32'h7777);
      for (int i = 0; i < 32; i++)
        for (int j = i + 1; j < 32; j++) begin
          src_req = (32'd1 << i) | (32'd1 << j);
          settle_check("R5 pair arbitration");
        end
    end

    // R6 R7 mask set and clear
    src_req = '1;
    wr(3'd4, 32'h0000_FFFF);
    settle_check("R6 mask set low half");
    wr(3'd4, 32'h0);
    settle_check("R6 zero set bits no effect");
    wr(3'd4, 32'hFFFF_0000);
    settle_check("R6 all masked");
    wr(3'd5, 32'h0F0F_0F0F);
    settle_check("R7 partial clear");
    wr(3'd5, 32'h0);
    settle_check("R7 zero clear bits no effect");
    for (int i = 0; i < 32; i++) begin
      wr(3'd5, 32'd1 << i);
      settle_check("R7 single clear");
    end
    wr(3'd4, 32'hFFFF_FFFF);
    settle_check("R6 mask all sources");

    // R8 external level sweep with and without competitors
    src_req = '0;
    for (int n = 0; n < 16; n++)
      for (int c = 0; c < 16; c += 5) begin
        ext_lvl = 4'(n); cpu_lvl = 4'(c);
        settle_check("R8 external level");
      end
    cpu_lvl = 4'h0;
    wr(3'd5, 32'hFFFF_FFFF);
    src_req = '1;
    for (int n = 0; n < 16; n++) begin
      ext_lvl = 4'(n);
      settle_check("R8 external vs internal incl tie");
    end
    ext_lvl = 4'hF;
    src_req = '0;

    // R11 ignored addresses and upper bits
    wr(3'd0, 32'hABCD_0005);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    src_req = 32'h1;
    m_prio[0] = 16'h0005;
    settle_check("R11 ignored writes");

    // R10 hold and drop on winner change
    for (int r = 1; r < 4; r++) wr(3'(r), 32'h0);
    wr(3'd0, 32'h0095);
    src_req = 32'h1;
    settle_check("R10 initial grant");
    @(negedge clk);
    src_req = 32'h3;
    @(negedge clk);
    chk("R10 drop keeps old code", 1'b0, 0, 0);
    n_chk++;
    if (irq_code !== 12'h400) begin
      n_fail++;
      $display("FAIL R10 held code: code=%h expected 400", irq_code);
    end
    @(negedge clk);
    chk("R10 reload new winner", 1'b1, 9, 'h420);
    cpu_lvl = 4'd9;
    @(negedge clk);
    chk("R9 R10 drop on cpu level rise", 1'b0, 0, 0);
    @(negedge clk);
    chk("R9 stays low at cpu level", 1'b0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule